// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to sixteen interrupt inputs from neighbouring peripherals and turns them into a single request level for the processor, from 0 (nothing pending) to 7. Each input has its own 8-bit control register. The register sets the request level, turns the input on or off, chooses between level-sensitive and edge-latched operation, chooses the active polarity, and clears a latched edge. The same register reports whether the input is currently active. Every input first passes through a two-flop synchroniser, so asynchronous peripheral lines may be wired straight in.

The block compares all sources that are enabled and active and drives the highest level found. When several sources share that level, the one with the larger source code wins. The processor acknowledges by pulsing `iack` with the level it is servicing. If that level matches the level the block is driving, the block returns an 8-bit vector one cycle later: the programmable vector base plus the 4-bit code of the winning source, taken modulo 256. A master enable in the general control register blocks every request while it is clear.

Register space on `cfg_addr`: addresses 0 to 15 are the source control registers, address 16 is general control, and address 17 is the vector base. Writes take effect at the clock edge where `cfg_we` is high. Reads are combinational on `cfg_rdata`. The acknowledge machine has two states. ACK_IDLE waits and takes the "accept" transition to ACK_DRIVE on a matching acknowledge; any other acknowledge keeps it in ACK_IDLE. ACK_DRIVE presents the vector for exactly one cycle and takes the "release" transition back to ACK_IDLE.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0, `vec_valid` is 0, `vec_out` is 0, and every register (addresses 0 to 17) reads 0x00.
- R2: A source control register reads back bits 2:0 (level), bit 4 (enable), bit 6 (trigger: 0 level, 1 edge) and bit 7 (polarity: 0 rising/high, 1 falling/low) exactly as written. Bit 3 always reads 0. Bit 5 reads the active status and ignores the value written to it.
- R3: In level mode the active bit (bit 5) equals the synchronised input XOR the polarity bit, and it follows the input in both directions.
- R4: In edge mode the active bit is set by the selected edge only (rising when bit 7 is 0, falling when bit 7 is 1). It stays set after the input returns to its idle value.
- R5: Writing a source control register with bit 3 set clears its latched edge. A write with bit 3 clear leaves the latch set.
- R6: A source with bit 4 clear makes no request, while its bit 5 still shows it as active.
- R7: A source whose level field is 0 never makes a request, even when it is enabled and active.
- R8: While bit 1 of the general control register (address 16) is 0, `irq_level` is 0 whatever the sources do.
- R9: `irq_level` equals the largest level among sources that are enabled, active and at a nonzero level, or 0 when there is none.
- R10: Among requesting sources at the winning level, the source with the highest code (its register address) supplies the vector.
- R11: After `iack` is high for one cycle with `iack_level` equal to a nonzero `irq_level`, `vec_valid` is high for exactly the next cycle and `vec_out` = (vector base + winning code) mod 256. An acknowledge with any other level gives no `vec_valid`.
- R12: A level-mode input change set up before clock edge k first shows on `irq_level` after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt inputs, bit i is source code i |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register address: 0..15 sources, 16 general control, 17 vector base |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| iack | input | 1 | Interrupt acknowledge pulse |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest pending request level, 0 for none |
| vec_valid | output | 1 | Vector on `vec_out` is valid this cycle |
| vec_out | output | 8 | Vector base plus winning source code |

## Verification
The hardest situation to reach from the ports is the tie-break combined with the edge latches. Several sources must be pending at the same level, some of them latched from earlier edges, some level-driven, and some masked by their enable or by a zero level. This depends on a history of input transitions and register writes, not on the present input pattern alone. The stimulus uses a seeded random walk that mixes register writes (with random clear bits), vector-base and master-enable writes, and input changes, and lets each change settle. A bench model replays every edge and clear and predicts the level, the vector and each register's read value. Directed cases add exact ties, acknowledges at the wrong level, vector-base wrap-around and the two-cycle synchroniser latency.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int LVL_W  = 3;
    localparam int REG_W  = 8;

    // control register bit positions (decoded by software)
    localparam int CR_LVL_HI = 2;
    localparam int CR_CLR    = 3;
    localparam int CR_EN     = 4;
    localparam int CR_ACT    = 5;
    localparam int CR_TRIG   = 6;
    localparam int CR_POL    = 7;
    localparam int GC_MASTER = 1;

    typedef struct packed {
        logic             pol;
        logic             trig;
        logic             en;
        logic             clr;
        logic [LVL_W-1:0] lvl;
    } src_wr_t;

    typedef enum logic [0:0] {
        ACK_IDLE  = 1'b0,
        ACK_DRIVE = 1'b1
    } ack_state_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/vic_source.sv
module vic_source
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  src_wr_t          wr_bits,
    input  logic             sync_in,
    input  logic             master_en,
    output logic [REG_W-1:0] ctrl_rd,
    output logic [LVL_W-1:0] lvl,
    output logic             req
);
    logic pol_q, trig_q, en_q;
    logic [LVL_W-1:0] lvl_q;
    logic prev_q, latch_q;
    logic edge_hit, active;

    // edge seen on the raw synchronised line, so a polarity change alone makes no edge
    assign edge_hit = pol_q ? (prev_q & ~sync_in) : (~prev_q & sync_in);
    assign active   = trig_q ? latch_q : (sync_in ^ pol_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= 1'b0;
            trig_q <= 1'b0;
            en_q   <= 1'b0;
            lvl_q  <= '0;
        end else if (wr_hit) begin
            pol_q  <= wr_bits.pol;
            trig_q <= wr_bits.trig;
            en_q   <= wr_bits.en;
            lvl_q  <= wr_bits.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
            if (!trig_q) latch_q <= 1'b0;
            if (wr_hit && wr_bits.clr) latch_q <= 1'b0;
            if (trig_q && edge_hit) latch_q <= 1'b1;   // a new edge wins over a clear
        end
    end

    assign req = active & en_q & (lvl_q != '0) & master_en;
    assign lvl = lvl_q;

    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[CR_LVL_HI:0]       = lvl_q;
        ctrl_rd[CR_EN]             = en_q;
        ctrl_rd[CR_ACT]            = active;
        ctrl_rd[CR_TRIG]           = trig_q;
        ctrl_rd[CR_POL]            = pol_q;
    end

    // R5: a latched edge survives every cycle without a write to this register
    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && latch_q && !wr_hit) |=> latch_q);
    // R4: the selected edge in edge mode always leaves the latch set
    assert_edge_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_q && edge_hit) |=> latch_q);
endmodule

// File: rtl/vic_prio.sv
module vic_prio
    import vic_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int CODE_W = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] lvl_flat,
    output logic [LVL_W-1:0]         lvl_q,
    output logic [CODE_W-1:0]        code_q
);
    logic [LVL_W-1:0]  best_lvl;
    logic [CODE_W-1:0] best_code;

    // ascending scan with >= lets the higher code win a tie
    always_comb begin
        best_lvl  = '0;
        best_code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (lvl_flat[i*LVL_W +: LVL_W] >= best_lvl)) begin
                best_lvl  = lvl_flat[i*LVL_W +: LVL_W];
                best_code = CODE_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q  <= '0;
            code_q <= '0;
        end else begin
            lvl_q  <= best_lvl;
            code_q <= best_code;
        end
    end

    // R9: no request in a cycle means level 0 in the next
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |=> (lvl_q == '0));
    // R9: a nonzero level is always backed by a request one cycle before
    assert_level_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != '0) |-> $past(|req));
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
    import vic_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iack,
    input  logic [LVL_W-1:0]  iack_level,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic [CODE_W-1:0] cur_code,
    input  logic [VEC_W-1:0]  vbase,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out
);
    ack_state_e state_q, state_d;
    logic       accept;
    logic [VEC_W-1:0] vec_q;

    assign accept = iack && (iack_level == cur_lvl) && (cur_lvl != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (accept) state_d = ACK_DRIVE;
            ACK_DRIVE: state_d = ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            vec_q <= '0;
        else if (state_q == ACK_IDLE && accept) vec_q <= vbase + VEC_W'(cur_code);
    end

    always_comb begin
        vec_valid = 1'b0;
        vec_out   = '0;
        unique case (state_q)
            ACK_IDLE:  ;
            ACK_DRIVE: begin
                vec_valid = 1'b1;
                vec_out   = vec_q;
            end
            default: ;
        endcase
    end

    // R11: the vector is presented for a single cycle
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);
    // R11: a matching acknowledge in idle is answered in the next cycle
    assert_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_IDLE && iack && iack_level == cur_lvl && cur_lvl != '0) |=> vec_valid);
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int VEC_W       = 8,
    localparam int ADDR_W     = $clog2(NUM_SRC + 2),
    localparam int CODE_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic               iack,
    input  logic [LVL_W-1:0]   iack_level,
    output logic [LVL_W-1:0]   irq_level,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_out
);
    localparam logic [ADDR_W-1:0] GC_ADDR = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] VB_ADDR = ADDR_W'(NUM_SRC + 1);

    logic [NUM_SRC-1:0]       synced;
    logic [NUM_SRC-1:0]       req;
    logic [NUM_SRC*LVL_W-1:0] lvl_flat;
    logic [REG_W-1:0]         src_rd [NUM_SRC];
    logic [REG_W-1:0]         gctrl_q;
    logic [VEC_W-1:0]         vbase_q;
    logic [CODE_W-1:0]        win_code;
    logic                     master_en;
    src_wr_t                  wr_bits;

    assign master_en = gctrl_q[GC_MASTER];
    assign wr_bits   = '{pol: cfg_wdata[CR_POL], trig: cfg_wdata[CR_TRIG],
                         en: cfg_wdata[CR_EN], clr: cfg_wdata[CR_CLR],
                         lvl: cfg_wdata[CR_LVL_HI:0]};

    vic_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_in), .q(synced)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        vic_source u_src (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (cfg_we && (cfg_addr == ADDR_W'(i))),
            .wr_bits   (wr_bits),
            .sync_in   (synced[i]),
            .master_en (master_en),
            .ctrl_rd   (src_rd[i]),
            .lvl       (lvl_flat[i*LVL_W +: LVL_W]),
            .req       (req[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gctrl_q <= '0;
            vbase_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == GC_ADDR) gctrl_q <= cfg_wdata;
            if (cfg_addr == VB_ADDR) vbase_q <= VEC_W'(cfg_wdata);
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (cfg_addr == ADDR_W'(i)) cfg_rdata = src_rd[i];
        if (cfg_addr == GC_ADDR) cfg_rdata = gctrl_q;
        if (cfg_addr == VB_ADDR) cfg_rdata = REG_W'(vbase_q);
    end

    vic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk(clk), .rst_n(rst_n), .req(req), .lvl_flat(lvl_flat),
        .lvl_q(irq_level), .code_q(win_code)
    );

    vic_ack_fsm #(.CODE_W(CODE_W), .VEC_W(VEC_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .iack(iack), .iack_level(iack_level),
        .cur_lvl(irq_level), .cur_code(win_code), .vbase(vbase_q),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // R8: with the master enable clear, the output level drops to 0 next cycle
    assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (irq_level == '0));
    // R7: a source with a zero level field never drives a request
    assert_zero_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_flat[LVL_W-1:0] == '0) |-> !req[0]);
endmodule

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       iack = 1'b0;
    logic [2:0] iack_level = '0;
    logic [2:0] irq_level;
    logic       vec_valid;
    logic [7:0] vec_out;

    always #2 clk = ~clk;

    vec_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .iack(iack), .iack_level(iack_level), .irq_level(irq_level),
        .vec_valid(vec_valid), .vec_out(vec_out)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model
    bit       m_pol [N];
    bit       m_trig[N];
    bit       m_en  [N];
    bit [2:0] m_lvl [N];
    bit       m_lat [N];
    bit [7:0] m_gc;
    bit [7:0] m_vb;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_act(input int i);
        return m_trig[i] ? m_lat[i] : (src_in[i] ^ m_pol[i]);
    endfunction

    function automatic bit exp_req(input int i);
        return exp_act(i) && m_en[i] && (m_lvl[i] != 0) && m_gc[1];
    endfunction

    function automatic int exp_level();
        int best = 0;
        for (int i = 0; i < N; i++) if (exp_req(i) && m_lvl[i] > best) best = m_lvl[i];
        return best;
    endfunction

    function automatic int exp_code();
        int best = 0;
        int code = 0;
        for (int i = 0; i < N; i++)
            if (exp_req(i) && m_lvl[i] >= best) begin best = m_lvl[i]; code = i; end
        return code;
    endfunction

    function automatic int exp_rd(input int i);
        return {m_pol[i], m_trig[i], exp_act(i), m_en[i], 1'b0, m_lvl[i]};
    endfunction

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input int a, input bit [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[4:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < N) begin
            m_pol[a] = d[7]; m_trig[a] = d[6]; m_en[a] = d[4]; m_lvl[a] = d[2:0];
            if (d[3] || !d[6]) m_lat[a] = 1'b0;
        end else if (a == N)     m_gc = d;
        else if (a == N + 1)     m_vb = d;
    endtask

    task automatic drive_in(input logic [N-1:0] v);
        for (int i = 0; i < N; i++)
            if (m_trig[i] && v[i] != src_in[i] && (v[i] != m_pol[i])) m_lat[i] = 1'b1;
        @(negedge clk);
        src_in = v;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        cfg_addr = a[4:0];
        #1 v = cfg_rdata;
    endtask

    task automatic do_iack(input bit [2:0] l, output bit got, output int v, output bit held);
        @(negedge clk);
        iack = 1'b1; iack_level = l;
        @(negedge clk);
        iack = 1'b0;
        got = vec_valid; v = vec_out;
        @(negedge clk);
        held = vec_valid;
    endtask

    task automatic check_vec(input string tag);
        bit got, held; int v;
        int l = exp_level();
        if (l == 0) return;
        do_iack(l[2:0], got, v, held);
        check({tag, " R11 valid"}, got, 1);
        check({tag, " R11 R10 vector"}, v, (m_vb + exp_code()) & 8'hFF);
        check({tag, " R11 one-cycle"}, held, 0);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) wr(i, 8'h08);
        drive_in('0);
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        bit got, held;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < N; i++) begin
            m_pol[i] = 0; m_trig[i] = 0; m_en[i] = 0; m_lvl[i] = 0; m_lat[i] = 0;
        end
        m_gc = 0; m_vb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_level", irq_level, 0);
        check("R1 vec_valid", vec_valid, 0);
        check("R1 vec_out", vec_out, 0);
        for (int a = 0; a < N + 2; a++) begin
            rd(a, v);
            check("R1 register", v, 0);
        end

        // R2 field layout: bit3 and written bit5 read 0, others read back
        wr(3, 8'hFD);
        rd(3, v);
        check("R2 readback", v, 8'hD5);
        wr(3, 8'h08);

        // R12 latency and R3 level mode
        wr(N, 8'h02);
        wr(N + 1, 8'h40);
        wr(2, 8'h15);
        settle();
        for (int i = 0; i < N; i++) if (m_trig[i]) m_lat[i] = m_lat[i];
        @(negedge clk);
        src_in[2] = 1'b1;
        @(negedge clk);
        check("R12 after k", irq_level, 0);
        @(negedge clk);
        check("R12 after k+1", irq_level, 0);
        @(negedge clk);
        check("R12 after k+2", irq_level, 5);
        rd(2, v);
        check("R3 active bit", v, 8'h35);
        do_iack(3'd5, got, v, held);
        check("R11 match valid", got, 1);
        check("R11 vector 0x40+2", v, 8'h42);
        check("R11 one-cycle", held, 0);
        do_iack(3'd4, got, v, held);
        check("R11 mismatch no valid", got, 0);
        check("R11 mismatch later", held, 0);
        drive_in('0);
        settle();
        check("R3 follows low", irq_level, 0);

        // R3 low polarity
        wr(2, 8'h95);
        settle();
        check("R3 low-active level", irq_level, 5);

        // R6 enable clear: no request but active shown
        wr(2, 8'h85);
        settle();
        check("R6 no request", irq_level, 0);
        rd(2, v);
        check("R6 active still shown", v, 8'hA5);

        // R7 zero level
        wr(2, 8'h90);
        settle();
        check("R7 zero level no request", irq_level, 0);
        wr(2, 8'h08);

        // R4 rising edge latch, R5 clear
        wr(7, 8'h53);
        settle();
        drive_in(16'h0080);
        settle();
        drive_in(16'h0000);
        settle();
        check("R4 rising latched", irq_level, 3);
        rd(7, v);
        check("R4 active bit held", v, 8'h73);
        wr(7, 8'h53);
        settle();
        check("R5 write w/o clear keeps", irq_level, 3);
        wr(7, 8'h5B);
        settle();
        check("R5 clear drops", irq_level, 0);
        // falling polarity
        wr(7, 8'hD3);
        settle();
        drive_in(16'h0080);
        settle();
        check("R4 falling ignores rise", irq_level, 0);
        drive_in(16'h0000);
        settle();
        check("R4 falling latched", irq_level, 3);
        wr(7, 8'h08);
        settle();

        // R9 R10 tie-break
        wr(4, 8'h16); wr(9, 8'h16); wr(12, 8'h12);
        drive_in(16'h1210);
        settle();
        check("R9 max level", irq_level, 6);
        check_vec("R10 tie high code 9");
        wr(4, 8'h17);
        settle();
        check("R9 new max", irq_level, 7);
        check_vec("R10 code 4");

        // R8 master enable
        wr(N, 8'h00);
        settle();
        check("R8 master off", irq_level, 0);
        wr(N, 8'h02);
        settle();
        check("R8 master on", irq_level, 7);

        // R11 wrap
        wr(N + 1, 8'hFE);
        wr(4, 8'h08);
        settle();
        check_vec("R11 wrap 0xFE+9");
        clear_all();

        // random walk
        for (int it = 0; it < 300; it++) begin
            int sel = $urandom_range(0, 99);
            if (sel < 50) begin
                int s = $urandom_range(0, N - 1);
                bit [7:0] d = 8'($urandom);
                if ($urandom_range(0, 3) != 0) d[4] = 1'b1;
                wr(s, d);
            end else if (sel < 58) begin
                bit [7:0] d = 8'($urandom);
                d[1] = ($urandom_range(0, 4) != 0);
                wr(N, d);
            end else if (sel < 65) begin
                wr(N + 1, 8'($urandom));
            end else begin
                drive_in(16'($urandom));
            end
            settle();
            check("R9 random level", irq_level, exp_level());
            begin
                int s = $urandom_range(0, N - 1);
                rd(s, v);
                check("R2 R3 R4 random readback", v, exp_rd(s));
            end
            check_vec("R10 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule